// File: doc/BRIEF.md
# Ping-Pong Receive Frame Buffer

This block takes received Ethernet frames from a byte-wide stream and keeps them in memory that software reads over a 32-bit word bus. There are two receive buffers, 0x800 bytes apart. Each buffer has a status word in its last location, and that word holds a done flag and an interrupt enable. Frames fill the buffers in strict turn, starting with buffer 0. When a frame ends, the block sets the done flag of the buffer it filled. That buffer then stays locked until software writes its status word with bit 0 cleared.

Software polls, or waits for the interrupt, then reads the frame words and acknowledges the buffer. If a frame starts while the buffer next in turn is still locked, the whole frame is discarded. The turn does not move on in that case, so software and hardware stay in step. A parameter reduces the block to a single buffer. In that mode every frame goes to buffer 0, and the second buffer's address range reads as zero.

Top module: `rx_pingpong_buffer`

## Requirements
- R1: After reset, both status words read 0, `irq` is low, `bus_rdata` is 0, and the first accepted frame goes to buffer 0.
- R2: Byte address 0x1000 + k*0x800 + 4*w holds data word w of buffer k, and 0x17FC + k*0x800 is buffer k's status word. Any address below 0x1000 reads 0. `bus_rdata` shows the addressed word from the clock edge that samples `bus_rd` and holds it until the next read.
- R3: Frame byte n is stored in word n/4, in bits [31-8*(n%4) -: 8], so the first byte of a word is its most significant byte. The unused low bytes of a frame's last partial word read 0. Idle cycles (`rx_valid` low) inside a frame do not change the stored bytes.
- R4: The clock edge that takes a frame's last byte (`rx_valid` and `rx_last` both high) sets bit 0 (done) of that buffer's status word.
- R5: In ping-pong mode, accepted frames go to buffers 0, 1, 0, 1, and so on.
- R6: A frame whose first byte arrives while the buffer next in turn has done set is dropped whole. No buffer contents change, no done flag is set, no interrupt is raised, and the next frame still targets the same buffer.
- R7: A write to a status word copies data bit 3 into the interrupt enable. Data bit 0 = 0 clears done. Data bit 0 = 1 leaves done unchanged. Status reads show done in bit 0 and the enable in bit 3, with all other bits 0.
- R8: Only the first 0x7FC bytes of a frame are stored. Later bytes are discarded, the status word is never overwritten, and done is still set when the frame ends.
- R9: `irq` is high for exactly one cycle, on the same edge that sets a done flag, and only when that buffer's interrupt enable is 1.
- R10: With PING_PONG = 0, every frame goes to buffer 0, a frame that starts while buffer 0's done is set is dropped, and the second buffer's data and status addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | The current byte is the last byte of its frame |
| bus_addr | input | ADDR_W (13) | Byte address for a read or write |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request (status words only) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read request |
| irq | output | 1 | One-cycle pulse when an enabled buffer becomes done |

## Verification
Frame lengths from 1 to 8 bytes exercise every position of the last partial word. Each frame's contents are read back and compared against a computed byte pattern, which catches errors in lane order and in zero padding. Some of these frames contain idle gaps, which shows that a stalled stream loses no bytes. A sequence that fills both buffers, frees only the buffer that is not next in turn, and then sends a frame distinguishes strict alternation from "use any free buffer". A 2050-byte frame checks the capacity clamp, and a second instance checks single-buffer mode.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_MEM  = 2'd1,
    RD_STAT = 2'd2
  } rd_src_e;

  function automatic logic [31:0] stat_word(input logic done, input logic ie);
    stat_word = {28'h0, ie, 2'b00, done};
  endfunction

endpackage

// File: rtl/rxpp_fill.sv
module rxpp_fill #(
  parameter int SPAN_LG2  = 11,
  parameter bit PING_PONG = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_valid,
  input  logic [7:0]          rx_data,
  input  logic                rx_last,
  input  logic [1:0]          done_vec,
  output logic                mem_we,
  output logic [SPAN_LG2-2:0] mem_waddr,
  output logic [31:0]         mem_wdata,
  output logic                set_done,
  output logic                cur_buf
);
  localparam int WIDX_W = SPAN_LG2 - 2;
  localparam int CAP    = ((1 << WIDX_W) - 1) * 4;

  logic                tgt_q;
  logic                busy_q;
  logic                drop_q;
  logic [SPAN_LG2-1:0] cnt_q;
  logic [31:0]         acc_q;

  logic       start, take, in_cap, word_end;
  logic [1:0] lane;
  logic [31:0] word;

  assign start    = rx_valid && !busy_q && !drop_q;
  assign take     = rx_valid && (busy_q || (start && !done_vec[tgt_q]));
  assign in_cap   = (32'(cnt_q) < CAP);
  assign lane     = cnt_q[1:0];
  assign word     = acc_q | ({rx_data, 24'h0} >> {lane, 3'b000});
  assign word_end = (lane == 2'd3) || rx_last;

  assign mem_we    = take && in_cap && word_end;
  assign mem_waddr = {tgt_q, cnt_q[SPAN_LG2-1:2]};
  assign mem_wdata = word;
  assign set_done  = take && rx_last;
  assign cur_buf   = tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q  <= 1'b0;
      busy_q <= 1'b0;
      drop_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else if (take) begin
      if (rx_last) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
        acc_q  <= '0;
        tgt_q  <= PING_PONG ? ~tgt_q : 1'b0;
      end else begin
        busy_q <= 1'b1;
        if (in_cap) begin
          cnt_q <= cnt_q + 1'b1;
          acc_q <= word_end ? 32'h0 : word;
        end
      end
    end else if (rx_valid && (start || drop_q)) begin
      drop_q <= !rx_last;
    end
  end

endmodule

// File: rtl/rxpp_mem.sv
module rxpp_mem #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  logic [31:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxpp_stat.sv
module rxpp_stat (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_done,
  input  logic       set_buf,
  input  logic       sw_we,
  input  logic       sw_buf,
  input  logic       sw_ie,
  input  logic       sw_keep,
  output logic [1:0] done_q,
  output logic [1:0] ie_q,
  output logic       irq
);
  for (genvar i = 0; i < 2; i++) begin : g_buf
    always_ff @(posedge clk) begin
      if (rst) begin
        done_q[i] <= 1'b0;
        ie_q[i]   <= 1'b0;
      end else begin
        if (sw_we && (sw_buf == 1'(i))) begin
          ie_q[i] <= sw_ie;
          if (!sw_keep) done_q[i] <= 1'b0;
        end
        if (set_done && (set_buf == 1'(i))) done_q[i] <= 1'b1;
      end
    end

    assert_done_held_R7: assert property (@(posedge clk) disable iff (rst)
      (done_q[i] && !(sw_we && (sw_buf == 1'(i)) && !sw_keep)) |=> done_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= set_done && ie_q[set_buf];
  end

  assert_irq_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|done_q));

endmodule

// File: rtl/rx_pingpong_buffer.sv
module rx_pingpong_buffer #(
  parameter int SPAN_LG2  = 11,
  parameter bit PING_PONG = 1'b1,
  localparam int ADDR_W   = SPAN_LG2 + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  import rxpp_pkg::*;

  localparam int WIDX_W = SPAN_LG2 - 2;
  localparam int MEM_AW = WIDX_W + (PING_PONG ? 1 : 0);

  logic              in_rx, bsel, is_stat, buf_ok, sw_we, re;
  logic [WIDX_W-1:0] widx;

  logic              mem_we, set_done, cur_buf;
  logic [WIDX_W:0]   fill_addr;
  logic [31:0]       fill_data, mem_q, stat_q;
  logic [MEM_AW-1:0] mem_waddr, mem_raddr;
  logic [1:0]        done_q, ie_q;
  rd_src_e           src_q;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:4], bus_wdata[2:1]};

  assign in_rx   = bus_addr[ADDR_W-1];
  assign bsel    = bus_addr[SPAN_LG2];
  assign widx    = bus_addr[SPAN_LG2-1:2];
  assign is_stat = &widx;
  assign buf_ok  = PING_PONG || !bsel;
  assign sw_we   = bus_wr && in_rx && is_stat && buf_ok;
  assign re      = bus_rd && in_rx && !is_stat && buf_ok;

  rxpp_fill #(.SPAN_LG2(SPAN_LG2), .PING_PONG(PING_PONG)) u_fill (
    .clk(clk), .rst(rst),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .done_vec(done_q),
    .mem_we(mem_we), .mem_waddr(fill_addr), .mem_wdata(fill_data),
    .set_done(set_done), .cur_buf(cur_buf)
  );

  if (PING_PONG) begin : g_two
    assign mem_waddr = fill_addr;
    assign mem_raddr = {bsel, widx};
  end else begin : g_one
    logic unused_top;
    assign unused_top = fill_addr[WIDX_W];
    assign mem_waddr  = fill_addr[WIDX_W-1:0];
    assign mem_raddr  = widx;
  end

  rxpp_mem #(.AW(MEM_AW)) u_mem (
    .clk(clk),
    .we(mem_we), .waddr(mem_waddr), .wdata(fill_data),
    .re(re), .raddr(mem_raddr), .rdata(mem_q)
  );

  rxpp_stat u_stat (
    .clk(clk), .rst(rst),
    .set_done(set_done), .set_buf(cur_buf),
    .sw_we(sw_we), .sw_buf(bsel), .sw_ie(bus_wdata[3]), .sw_keep(bus_wdata[0]),
    .done_q(done_q), .ie_q(ie_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= RD_ZERO;
      stat_q <= '0;
    end else if (bus_rd) begin
      stat_q <= stat_word(done_q[bsel], ie_q[bsel]);
      if (!in_rx || !buf_ok) src_q <= RD_ZERO;
      else if (is_stat)      src_q <= RD_STAT;
      else                   src_q <= RD_MEM;
    end
  end

  always_comb begin
    case (src_q)
      RD_MEM:  bus_rdata = mem_q;
      RD_STAT: bus_rdata = stat_q;
      default: bus_rdata = '0;
    endcase
  end

  assert_no_fill_locked_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !done_q[cur_buf]);
  assert_status_slot_safe_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (fill_addr[WIDX_W-1:0] != {WIDX_W{1'b1}}));
  assert_done_from_free_R4: assert property (@(posedge clk) disable iff (rst)
    set_done |-> !done_q[cur_buf]);
  assert_single_buf_R10: assert property (@(posedge clk) disable iff (rst)
    (!PING_PONG && set_done) |-> !cur_buf);

endmodule

// File: tb/rx_pingpong_buffer_tb.sv
module rx_pingpong_buffer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        p_valid = 0, p_last = 0, p_rd = 0, p_wr = 0, p_irq;
  logic [7:0]  p_data = 0;
  logic [12:0] p_addr = 0;
  logic [31:0] p_wdata = 0, p_rdata;
  logic        s_valid = 0, s_last = 0, s_rd = 0, s_wr = 0, s_irq;
  logic [7:0]  s_data = 0;
  logic [12:0] s_addr = 0;
  logic [31:0] s_wdata = 0, s_rdata;

  rx_pingpong_buffer #(.SPAN_LG2(11), .PING_PONG(1'b1)) u_dut (
    .clk(clk), .rst(rst), .rx_valid(p_valid), .rx_data(p_data), .rx_last(p_last),
    .bus_addr(p_addr), .bus_rd(p_rd), .bus_wr(p_wr), .bus_wdata(p_wdata),
    .bus_rdata(p_rdata), .irq(p_irq));

  rx_pingpong_buffer #(.SPAN_LG2(11), .PING_PONG(1'b0)) u_dut_sb (
    .clk(clk), .rst(rst), .rx_valid(s_valid), .rx_data(s_data), .rx_last(s_last),
    .bus_addr(s_addr), .bus_rd(s_rd), .bus_wr(s_wr), .bus_wdata(s_wdata),
    .bus_rdata(s_rdata), .irq(s_irq));

  int checks = 0, errors = 0;
  int irq_cnt = 0, irq_long = 0, s_irq_cnt = 0;
  logic irq_prev = 0;

  always @(negedge clk) begin
    if (p_irq) irq_cnt++;
    if (p_irq && irq_prev) irq_long++;
    irq_prev = p_irq;
    if (s_irq) s_irq_cnt++;
  end

  function automatic logic [7:0] fbyte(int seed, int i);
    return 8'((seed * 13 + i * 7 + (i >> 8)) & 255);
  endfunction

  function automatic logic [31:0] fword(int seed, int len, int w);
    logic [31:0] r = 0;
    for (int b = 0; b < 4; b++) begin
      int idx = 4 * w + b;
      if (idx < len && idx < 2044) r[31-8*b -: 8] = fbyte(seed, idx);
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic send(bit sb, int len, int seed, bit gap);
    for (int i = 0; i < len; i++) begin
      if (gap && (i % 3 == 2)) begin
        @(negedge clk);
        if (sb) s_valid = 0; else p_valid = 0;
      end
      @(negedge clk);
      if (sb) begin s_valid = 1; s_data = fbyte(seed, i); s_last = (i == len - 1); end
      else    begin p_valid = 1; p_data = fbyte(seed, i); p_last = (i == len - 1); end
    end
    @(negedge clk);
    p_valid = 0; p_last = 0; s_valid = 0; s_last = 0;
  endtask

  task automatic rd(bit sb, logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    if (sb) begin s_rd = 1; s_addr = a; end else begin p_rd = 1; p_addr = a; end
    @(negedge clk);
    s_rd = 0; p_rd = 0;
    d = sb ? s_rdata : p_rdata;
  endtask

  task automatic wr(bit sb, logic [12:0] a, logic [31:0] d);
    @(negedge clk);
    if (sb) begin s_wr = 1; s_addr = a; s_wdata = d; end
    else    begin p_wr = 1; p_addr = a; p_wdata = d; end
    @(negedge clk);
    s_wr = 0; p_wr = 0;
  endtask

  function automatic logic [12:0] st_a(int b);
    return 13'(32'h17FC + b * 32'h800);
  endfunction

  task automatic chk_frame(bit sb, string tag, int b, int len, int seed);
    logic [31:0] d;
    int nw = (len + 3) / 4;
    if (nw > 511) nw = 511;
    for (int w = 0; w < nw; w++) begin
      rd(sb, 13'(32'h1000 + b * 32'h800 + 4 * w), d);
      chk(tag, d, fword(seed, len, w));
    end
  endtask

  task automatic chk_stat(bit sb, string tag, int b, logic [31:0] exp);
    logic [31:0] d;
    rd(sb, st_a(b), d);
    chk(tag, d, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int tgt, icnt, other;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", p_rdata, 0);
    chk("R1 irq", 32'(p_irq), 0);
    chk_stat(0, "R1 status0", 0, 0);
    chk_stat(0, "R1 status1", 1, 0);
    // R2 unmapped region
    rd(0, 13'h0FFC, d); chk("R2 unmapped", d, 0);
    rd(0, 13'h0000, d); chk("R2 unmapped0", d, 0);
    // R7 flush with interrupt enable
    wr(0, st_a(0), 32'h8); wr(0, st_a(1), 32'h8);
    chk_stat(0, "R7 ie set 0", 0, 32'h8);
    chk_stat(0, "R7 ie set 1", 1, 32'h8);
    wr(0, st_a(0), 32'h9);
    chk_stat(0, "R7 bit0 write keeps clear", 0, 32'h8);

    // R3 R4 R5 R9 sweep over lengths
    tgt = 0;
    for (int len = 1; len <= 8; len++) begin
      icnt = irq_cnt;
      send(0, len, len + 3, len >= 5);
      chk_stat(0, "R4 done set", tgt, 32'h9);
      chk_stat(0, "R5 other untouched", 1 - tgt, 32'h8);
      chk("R9 irq count", 32'(irq_cnt), 32'(icnt + 1));
      chk_frame(0, "R3 contents", tgt, len, len + 3);
      wr(0, st_a(tgt), 32'h8);
      chk_stat(0, "R7 ack", tgt, 32'h8);
      tgt = 1 - tgt;
    end
    chk("R9 pulse width", 32'(irq_long), 0);

    // R6 drop with strict alternation
    other = 1 - tgt;
    send(0, 12, 100, 0);
    send(0, 10, 101, 0);
    chk_stat(0, "R6 A done", tgt, 32'h9);
    chk_stat(0, "R6 B done", other, 32'h9);
    icnt = irq_cnt;
    send(0, 9, 102, 0);
    chk("R6 no irq on drop", 32'(irq_cnt), 32'(icnt));
    chk_frame(0, "R6 A kept", tgt, 12, 100);
    chk_frame(0, "R6 B kept", other, 10, 101);
    wr(0, st_a(other), 32'h8);
    send(0, 7, 103, 0);
    chk_stat(0, "R6 turn not advanced", other, 32'h8);
    chk("R6 no irq second drop", 32'(irq_cnt), 32'(icnt));
    wr(0, st_a(tgt), 32'h9);
    chk_stat(0, "R7 bit0 keeps done", tgt, 32'h9);
    wr(0, st_a(tgt), 32'h8);
    send(0, 6, 104, 0);
    chk_stat(0, "R6 E done", tgt, 32'h9);
    chk_frame(0, "R6 E stored", tgt, 6, 104);
    chk_frame(0, "R6 B untouched", other, 10, 101);
    wr(0, st_a(tgt), 32'h8);
    tgt = other;

    // R9 interrupt disabled
    wr(0, st_a(tgt), 32'h0);
    icnt = irq_cnt;
    send(0, 5, 105, 0);
    chk_stat(0, "R9 done without ie", tgt, 32'h1);
    chk("R9 no irq when disabled", 32'(irq_cnt), 32'(icnt));
    wr(0, st_a(tgt), 32'h8);
    tgt = 1 - tgt;

    // R8 overflow
    icnt = irq_cnt;
    send(0, 2050, 106, 0);
    chk_stat(0, "R8 done after overflow", tgt, 32'h9);
    chk("R8 irq", 32'(irq_cnt), 32'(icnt + 1));
    chk_frame(0, "R8 contents", tgt, 2050, 106);

    // R10 single-buffer mode
    wr(1, st_a(0), 32'h8);
    send(1, 6, 200, 0);
    chk_stat(1, "R10 done0", 0, 32'h9);
    chk("R10 irq", 32'(s_irq_cnt), 1);
    rd(1, 13'h1FFC, d); chk("R10 second status zero", d, 0);
    rd(1, 13'h1800, d); chk("R10 second data zero", d, 0);
    send(1, 5, 201, 0);
    chk_frame(1, "R10 drop keeps frame", 0, 6, 200);
    chk("R10 no irq on drop", 32'(s_irq_cnt), 1);
    wr(1, st_a(0), 32'h8);
    send(1, 7, 202, 0);
    chk_frame(1, "R10 buffer0 again", 0, 7, 202);
    chk_stat(1, "R10 done again", 0, 32'h9);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule